// File: doc/BRIEF.md
# Dual Window Mask Generator

This block decides, pixel by pixel along a scanline, which display layers are hidden by two horizontal clipping windows. Each window is a span of pixel columns set by a left edge and a right edge. Six layers each choose whether to use each window, whether to invert it, and how to join the two windows: four background layers, the sprite layer and the colour window. The result for a layer is a mask bit. A true value means the layer is hidden at that pixel.

Software writes the configuration onto the configuration inputs and pulses a load strobe. The block captures the configuration on that clock edge. After that, the pixel position drives the masks through combinational logic, so every output follows the position within the same cycle. The five maskable layers are gated separately for the main screen and the sub screen by two destination bit sets. The colour-window result goes out ungated, for use by the colour-math stage downstream.

Top module: `win_mask_top`

## Requirements
- R1: Window k (k = 1, 2) is true when its left edge ≤ `pixelX` ≤ its right edge. Both edges are included in the span.
- R2: When a window's left edge is greater than its right edge, that window is false at every pixel position.
- R3: For layer i, the four bits `winSel[4i+3:4i]` are: bit 0 inverts window 1, bit 1 enables window 1, bit 2 inverts window 2 and bit 3 enables window 2. Inversion takes the complement of the window before the two windows are joined.
- R4: A layer with neither window enabled has a false result, so it is never masked.
- R5: A layer with exactly one window enabled takes that window, after any inversion, as its result. The operator is ignored.
- R6: A layer with both windows enabled joins them with the operator in `winOp[2i+1:2i]`: 00 = OR, 01 = AND, 10 = XOR, 11 = XNOR.
- R7: `mainMask[j]` equals the result of layer j AND `mainDest[j]`. Layers j = 0..3 are background layers 1 to 4 and j = 4 is the sprite layer.
- R8: `subMask[j]` equals the result of layer j AND `subDest[j]`, with the same layer numbering as R7.
- R9: `colorWin` equals the result of layer 5. It does not depend on `mainDest` or `subDest`.
- R10: All configuration inputs are captured on a rising clock edge where `cfgLoad` is 1. When `cfgLoad` is 0, changes to the configuration inputs have no effect on the outputs.
- R11: After reset, the captured configuration is all zero and every output is 0.
- R12: The outputs depend combinationally on `pixelX` and the captured configuration, so they are valid in the same cycle as the pixel position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Captures all configuration inputs on this edge |
| win1Left | input | 8 | Window 1 left edge |
| win1Right | input | 8 | Window 1 right edge |
| win2Left | input | 8 | Window 2 left edge |
| win2Right | input | 8 | Window 2 right edge |
| winSel | input | 24 | Per-layer enable and invert bits, 4 per layer |
| winOp | input | 12 | Per-layer 2-bit operator codes |
| mainDest | input | 5 | Main-screen mask enables |
| subDest | input | 5 | Sub-screen mask enables |
| pixelX | input | 8 | Current horizontal pixel position |
| mainMask | output | 5 | Main-screen mask per layer |
| subMask | output | 5 | Sub-screen mask per layer |
| colorWin | output | 1 | Raw colour-window result |

## Verification
The hardest case to reach is a pixel that sits exactly on a window edge while the two windows overlap or one of them is empty. Only that case separates the operator codes from each other and exposes off-by-one range logic. Random pixel positions almost never land there. So every configuration, random or directed, is swept over both edges of both windows, the positions one step outside each edge, and 0 and 255. Directed configurations also force left greater than right, and left equal to right.

// File: rtl/win_mask_pkg.sv
package win_mask_pkg;
  localparam int POS_W      = 8;
  localparam int MASK_LAYERS = 5;
  localparam int NUM_LAYERS = MASK_LAYERS + 1;
  localparam int NUM_WIN    = 2;
  localparam int SEL_BITS   = 2 * NUM_WIN;
  localparam int OP_BITS    = 2;
  localparam int SEL_W      = NUM_LAYERS * SEL_BITS;
  localparam int OP_W       = NUM_LAYERS * OP_BITS;

  typedef enum logic [1:0] {
    OP_OR   = 2'b00,
    OP_AND  = 2'b01,
    OP_XOR  = 2'b10,
    OP_XNOR = 2'b11
  } winOpE;

  typedef struct packed {
    logic loadCfg;
  } ctrlStrbS;

  function automatic logic joinWin(input logic [SEL_BITS-1:0] sel,
                                   input logic [OP_BITS-1:0] op,
                                   input logic w1, input logic w2);
    logic a, b;
    a = w1 ^ sel[0];
    b = w2 ^ sel[2];
    case ({sel[3], sel[1]})
      2'b00: return 1'b0;
      2'b01: return a;
      2'b10: return b;
      default: begin
        case (winOpE'(op))
          OP_OR:   return a | b;
          OP_AND:  return a & b;
          OP_XOR:  return a ^ b;
          default: return ~(a ^ b);
        endcase
      end
    endcase
  endfunction
endpackage

// File: rtl/win_mask_ctrl.sv
module win_mask_ctrl
  import win_mask_pkg::*;
(
  input  logic     cfgLoad,
  output ctrlStrbS strb
);
  always_comb begin
    strb = '0;
    strb.loadCfg = cfgLoad;
  end
endmodule

// File: rtl/win_mask_dp.sv
module win_mask_dp
  import win_mask_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrbS               strb,
  input  logic [NUM_WIN*POS_W-1:0] leftIn,
  input  logic [NUM_WIN*POS_W-1:0] rightIn,
  input  logic [SEL_W-1:0]       selIn,
  input  logic [OP_W-1:0]        opIn,
  input  logic [MASK_LAYERS-1:0] mainIn,
  input  logic [MASK_LAYERS-1:0] subIn,
  input  logic [POS_W-1:0]       pixelX,
  output logic [MASK_LAYERS-1:0] mainMask,
  output logic [MASK_LAYERS-1:0] subMask,
  output logic                   colorWin
);
  logic [POS_W-1:0]       leftQ  [NUM_WIN];
  logic [POS_W-1:0]       rightQ [NUM_WIN];
  logic [SEL_W-1:0]       selQ;
  logic [OP_W-1:0]        opQ;
  logic [MASK_LAYERS-1:0] mainQ, subQ;
  logic [NUM_WIN-1:0]     winHit;
  logic [NUM_LAYERS-1:0]  layerRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      opQ   <= '0;
      mainQ <= '0;
      subQ  <= '0;
    end else if (strb.loadCfg) begin
      selQ  <= selIn;
      opQ   <= opIn;
      mainQ <= mainIn;
      subQ  <= subIn;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        leftQ[w]  <= '0;
        rightQ[w] <= '0;
      end else if (strb.loadCfg) begin
        leftQ[w]  <= leftIn[w*POS_W +: POS_W];
        rightQ[w] <= rightIn[w*POS_W +: POS_W];
      end
    end

    assign winHit[w] = (pixelX >= leftQ[w]) && (pixelX <= rightQ[w]);

    // R2
    empty_win_chk: assert property (@(posedge clk) disable iff (!rstN)
      (leftQ[w] > rightQ[w]) |-> !winHit[w]);
  end

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
    assign layerRes[i] = joinWin(selQ[i*SEL_BITS +: SEL_BITS],
                                 opQ[i*OP_BITS +: OP_BITS],
                                 winHit[0], winHit[1]);

    // R4
    no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!selQ[i*SEL_BITS+1] && !selQ[i*SEL_BITS+3]) |-> !layerRes[i]);
  end

  assign mainMask = layerRes[MASK_LAYERS-1:0] & mainQ;
  assign subMask  = layerRes[MASK_LAYERS-1:0] & subQ;
  assign colorWin = layerRes[NUM_LAYERS-1];

  // R7
  main_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainMask & ~mainQ) == '0);

  // R8
  sub_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subMask & ~subQ) == '0);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCfg |=> ($stable(selQ) && $stable(opQ) && $stable(mainQ) && $stable(subQ)));
endmodule

// File: rtl/win_mask_top.sv
module win_mask_top
  import win_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgLoad,
  input  logic [7:0]  win1Left,
  input  logic [7:0]  win1Right,
  input  logic [7:0]  win2Left,
  input  logic [7:0]  win2Right,
  input  logic [23:0] winSel,
  input  logic [11:0] winOp,
  input  logic [4:0]  mainDest,
  input  logic [4:0]  subDest,
  input  logic [7:0]  pixelX,
  output logic [4:0]  mainMask,
  output logic [4:0]  subMask,
  output logic        colorWin
);
  ctrlStrbS strb;

  win_mask_ctrl u_ctrl (
    .cfgLoad (cfgLoad),
    .strb    (strb)
  );

  win_mask_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .leftIn   ({win2Left, win1Left}),
    .rightIn  ({win2Right, win1Right}),
    .selIn    (winSel),
    .opIn     (winOp),
    .mainIn   (mainDest),
    .subIn    (subDest),
    .pixelX   (pixelX),
    .mainMask (mainMask),
    .subMask  (subMask),
    .colorWin (colorWin)
  );

  // R12
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pixelX) && !$past(cfgLoad)) |-> ($stable(mainMask) && $stable(subMask) && $stable(colorWin)));
endmodule

// File: tb/sim_win_mask_top.sv
module sim_win_mask_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [7:0]  win1Left = '0, win1Right = '0, win2Left = '0, win2Right = '0;
  logic [23:0] winSel = '0;
  logic [11:0] winOp = '0;
  logic [4:0]  mainDest = '0, subDest = '0;
  logic [7:0]  pixelX = '0;
  logic [4:0]  mainMask, subMask;
  logic        colorWin;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  int mL1, mR1, mL2, mR2;
  logic [23:0] mSel;
  logic [11:0] mOp;
  logic [4:0]  mMain, mSub;

  always #4 clk = ~clk;

  win_mask_top u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .win1Left(win1Left), .win1Right(win1Right),
    .win2Left(win2Left), .win2Right(win2Right),
    .winSel(winSel), .winOp(winOp),
    .mainDest(mainDest), .subDest(subDest),
    .pixelX(pixelX),
    .mainMask(mainMask), .subMask(subMask), .colorWin(colorWin)
  );

  function automatic bit expLayer(int i, int x);
    bit w1, w2, a, b;
    logic [3:0] s;
    logic [1:0] o;
    w1 = (x >= mL1) && (x <= mR1);
    w2 = (x >= mL2) && (x <= mR2);
    s = mSel[i*4 +: 4];
    o = mOp[i*2 +: 2];
    a = w1 ^ s[0];
    b = w2 ^ s[2];
    if (!s[1] && !s[3]) return 0;
    if (s[1] && !s[3]) return a;
    if (!s[1] && s[3]) return b;
    case (o)
      2'b00: return a | b;
      2'b01: return a & b;
      2'b10: return a ^ b;
      default: return !(a ^ b);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadCfg(int l1, int r1, int l2, int r2, logic [23:0] s,
                         logic [11:0] o, logic [4:0] m, logic [4:0] sb);
    @(negedge clk);
    win1Left = l1[7:0]; win1Right = r1[7:0];
    win2Left = l2[7:0]; win2Right = r2[7:0];
    winSel = s; winOp = o; mainDest = m; subDest = sb;
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    mL1 = l1; mR1 = r1; mL2 = l2; mR2 = r2;
    mSel = s; mOp = o; mMain = m; mSub = sb;
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 R12: combinational result checked at the same pixel
  task automatic checkPix(int x, string tag);
    logic [4:0] em, es;
    logic [5:0] res;
    pixelX = x[7:0];
    #1;
    for (int i = 0; i < 6; i++) res[i] = expLayer(i, x);
    em = res[4:0] & mMain;
    es = res[4:0] & mSub;
    check({tag, " R7 mainMask"}, int'(mainMask), int'(em));
    check({tag, " R8 subMask"}, int'(subMask), int'(es));
    check({tag, " R9 colorWin"}, int'(colorWin), int'(res[5]));
  endtask

  task automatic sweep(string tag);
    int pts[12];
    pts = '{0, 255, mL1, mR1, mL2, mR2, mL1-1, mR1+1, mL2-1, mR2+1, 128, 64};
    foreach (pts[k]) begin
      if (pts[k] >= 0 && pts[k] <= 255) checkPix(pts[k], tag);
    end
    for (int k = 0; k < 4; k++) checkPix($urandom_range(255), tag);
    @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    mL1 = 0; mR1 = 0; mL2 = 0; mR2 = 0;
    mSel = '0; mOp = '0; mMain = '0; mSub = '0;
    // fill inputs with non-zero values to show that reset alone sets the captured config
    win1Left = 8'd3; win1Right = 8'd200; winSel = '1; mainDest = '1; subDest = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state: captured config is zero, so every output is zero
    pixelX = 8'd0; #1;
    check("R11 mainMask reset", int'(mainMask), 0);
    check("R11 subMask reset", int'(subMask), 0);
    check("R11 colorWin reset", int'(colorWin), 0);

    // R1 inclusive edges, window 1 only, every layer enabled on window 1
    loadCfg(10, 20, 0, 0, {6{4'b0010}}, '0, 5'h1F, 5'h1F);
    sweep("R1 R5 win1 only");
    // R3 inversion of window 1
    loadCfg(10, 20, 0, 0, {6{4'b0011}}, '0, 5'h1F, 5'h0A);
    sweep("R3 win1 inverted");
    // R2 empty window 1 (left > right), window 2 alone and then joined
    loadCfg(50, 40, 30, 60, {6{4'b1010}}, {6{2'b00}}, 5'h1F, 5'h1F);
    sweep("R2 R6 empty OR");
    loadCfg(50, 40, 30, 60, {6{4'b0011}}, {6{2'b01}}, 5'h1F, 5'h1F);
    sweep("R2 R3 empty inverted");
    // R1 single-pixel window (left == right)
    loadCfg(77, 77, 200, 100, {6{4'b0010}}, '0, 5'h1F, 5'h1F);
    sweep("R1 single pixel");
    // R6 each operator on overlapping windows, one layer per operator
    loadCfg(10, 40, 30, 70, {6{4'b1010}}, {2'b11, 2'b10, 2'b11, 2'b10, 2'b01, 2'b00},
            5'h1F, 5'h1F);
    sweep("R6 operators");
    loadCfg(10, 40, 30, 70, {6{4'b1110}}, {2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00},
            5'h15, 5'h0E);
    sweep("R6 R3 ops win2 inverted");
    // R4 nothing enabled but operator XNOR would otherwise be true
    loadCfg(0, 255, 0, 255, {6{4'b0101}}, {6{2'b11}}, 5'h1F, 5'h1F);
    sweep("R4 no enable");
    // R5 window 2 only, operator ignored
    loadCfg(0, 255, 100, 150, {6{4'b1000}}, {6{2'b01}}, 5'h1F, 5'h1F);
    sweep("R5 win2 only");
    // R9 colour window ignores destination bits
    loadCfg(0, 255, 0, 0, {4'b0010, 20'h0}, '0, 5'h00, 5'h00);
    sweep("R9 color ungated");

    // R10 configuration inputs change without cfgLoad: outputs must follow the old config
    @(negedge clk);
    win1Left = 8'd0; win1Right = 8'd0; winSel = '1; winOp = '1;
    mainDest = 5'h1F; subDest = 5'h1F;
    repeat (2) @(negedge clk);
    sweep("R10 no load");

    // random configurations
    for (int n = 0; n < 60; n++) begin
      loadCfg($urandom_range(255), $urandom_range(255), $urandom_range(255),
              $urandom_range(255), 24'($urandom), 12'($urandom),
              5'($urandom), 5'($urandom));
      sweep("R6 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nRun++;
        nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule